// File: doc/BRIEF.md
# Transfer Byte Counter and Address Tracker

This block follows the progress of a byte transfer on a storage bus data path. It keeps a 24-bit count of bytes still to move and a 32-bit host byte address. Each time the data path confirms that one byte has really crossed the bus, it pulses `xfer_ok`. On that pulse the count goes down by one and the address goes up by one. A byte that has only been queued does not move either of them, so the address always names the next byte that will truly transfer, even when the host side has fetched ahead.

Software sets up the block through a byte-wide register port. The count is written one byte at a time. A control bit zeroes the count. The address is loaded from a 32-bit input with a load strobe and can only be read through the register port. Two sticky status flags are kept. The done flag is set when a confirmed byte brings the count to zero. The wrap flag is set when a byte is confirmed while the count is already zero. Each flag is cleared by writing 1 to it. Each flag has its own enable, and the interrupt output is the OR of the flags that are both set and enabled.

Top module: `xfer_tracker`

## Requirements
- R1: After reset, the count, the address, both status flags and both enables are zero, and `irq` is low.
- R2: A write to offset 0, 1 or 2 loads count bits 7:0, 15:8 or 23:16 respectively. The same offsets read back those bytes, and the other count bytes are unchanged.
- R3: Each cycle with `xfer_ok` high and no count load decrements the count by 1 modulo 2^24. Each cycle with `xfer_ok` high and `haddr_load` low increments the address by 1 modulo 2^32.
- R4: When a count byte is written in the same cycle as `xfer_ok`, the written byte is loaded and the count is not decremented. The address still steps.
- R5: The done flag is status bit 0 at offset 5. It is set when a step takes the count from 1 to 0, and it stays set when a nonzero value is then loaded into the count.
- R6: The wrap flag is status bit 1 at offset 5. A step taken while the count is 0 leaves the count at 0xFFFFFF, sets wrap, and does not set done.
- R7: Writing offset 5 clears each status flag whose data bit is 1 and leaves flags whose data bit is 0. If a flag is set and cleared in the same cycle, the set wins.
- R8: Writing offset 4 with bit 0 equal to 1 zeroes the count without setting done. Writing it with bit 0 equal to 0 has no effect, and offset 4 reads as zero.
- R9: Offsets 8 to 11 read the address, lowest byte first, and ignore writes. A cycle with `haddr_load` high loads the address from `haddr_in`, and this load takes priority over a step in the same cycle.
- R10: Offset 6 holds the enables, bit 0 for done and bit 1 for wrap. `irq` is high exactly when some status flag is set and its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| xfer_ok | input | 1 | One byte confirmed as transferred on the bus |
| haddr_load | input | 1 | Load the address from `haddr_in` |
| haddr_in | input | 32 | Host byte address to load |
| irq | output | 1 | Interrupt: OR of the set and enabled status flags |

## Verification
The assertions assume that `xfer_ok`, `reg_wr` and `haddr_load` are single-cycle qualifiers held for one clock each. They also assume that a cycle with `reg_wr` high carries a stable offset and stable data. The step properties are written only for cycles without a register write, so the assertions do not settle how a write to the control or status offsets affects a step in the same cycle. The bench drives every input on the falling edge and holds it for exactly one rising edge. Its only same-cycle collisions are the ones the requirements define: a count write with a step, a status clear with a wrap, and an address load with a step.

// File: rtl/xfer_tracker.sv
module xfer_tracker #(
  parameter int CNT_W = 24,
  parameter int ADR_W = 32,
  parameter int RA_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             xfer_ok,
  input  logic             haddr_load,
  input  logic [ADR_W-1:0] haddr_in,
  output logic             irq
);
  localparam int CNT_B = CNT_W / 8;
  localparam int ADR_B = ADR_W / 8;
  localparam logic [RA_W-1:0] OFS_CTRL = RA_W'(4);
  localparam logic [RA_W-1:0] OFS_STAT = RA_W'(5);
  localparam logic [RA_W-1:0] OFS_EN   = RA_W'(6);
  localparam int OFS_ADR = 8;

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [ADR_W-1:0] haddr;
  logic             done, wrap;
  logic [1:0]       en;
  logic             cnt_wr, step;

  wire stat_wr  = reg_wr && reg_addr == OFS_STAT;
  wire done_set = step && cnt == CNT_W'(1);
  wire wrap_set = step && cnt == '0;

  always_comb begin
    cnt_nxt = cnt;
    cnt_wr  = 1'b0;
    for (int b = 0; b < CNT_B; b++)
      if (reg_wr && reg_addr == RA_W'(b)) begin
        cnt_nxt[b*8 +: 8] = reg_wdata;
        cnt_wr = 1'b1;
      end
    if (reg_wr && reg_addr == OFS_CTRL && reg_wdata[0]) begin
      cnt_nxt = '0;
      cnt_wr  = 1'b1;
    end
    step = xfer_ok && !cnt_wr;
    if (step) cnt_nxt = cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      haddr <= '0;
      done  <= 1'b0;
      wrap  <= 1'b0;
      en    <= 2'b00;
    end else begin
      cnt  <= cnt_nxt;
      done <= done_set | (done & ~(stat_wr & reg_wdata[0]));
      wrap <= wrap_set | (wrap & ~(stat_wr & reg_wdata[1]));
      if (reg_wr && reg_addr == OFS_EN) en <= reg_wdata[1:0];
      if (haddr_load)   haddr <= haddr_in;
      else if (xfer_ok) haddr <= haddr + ADR_W'(1);
    end

  always_comb begin
    reg_rdata = 8'h00;
    for (int b = 0; b < CNT_B; b++)
      if (reg_addr == RA_W'(b)) reg_rdata = cnt[b*8 +: 8];
    for (int b = 0; b < ADR_B; b++)
      if (reg_addr == RA_W'(OFS_ADR + b)) reg_rdata = haddr[b*8 +: 8];
    if (reg_addr == OFS_STAT) reg_rdata = {6'b0, wrap, done};
    if (reg_addr == OFS_EN)   reg_rdata = {6'b0, en};
  end

  assign irq = (done & en[0]) | (wrap & en[1]);
endmodule

// File: rtl/xfer_tracker_chk.sv
module xfer_tracker_chk #(
  parameter int CNT_W = 24,
  parameter int ADR_W = 32,
  parameter int RA_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [RA_W-1:0]  reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             xfer_ok,
  input logic             haddr_load,
  input logic [ADR_W-1:0] haddr_in,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [ADR_W-1:0] haddr,
  input logic             done,
  input logic             wrap,
  input logic [1:0]       en
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ok && !reg_wr) |=> cnt == $past(cnt) - CNT_W'(1)); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_ok && !reg_wr) |=> $stable(cnt)); // R2
  AST_ADR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ok && !haddr_load) |=> haddr == $past(haddr) + ADR_W'(1)); // R3
  AST_ADR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    haddr_load |=> haddr == $past(haddr_in)); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0 && xfer_ok) |=> cnt[7:0] == $past(reg_wdata)); // R4
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ok && !reg_wr && cnt == CNT_W'(1)) |=> done); // R5
  AST_WRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ok && !reg_wr && cnt == '0) |=> wrap && cnt == '1); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !reg_wr) |=> done); // R7
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 2'b00) |-> !irq); // R10
endmodule

bind xfer_tracker xfer_tracker_chk #(.CNT_W(CNT_W), .ADR_W(ADR_W), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .xfer_ok(xfer_ok), .haddr_load(haddr_load),
  .haddr_in(haddr_in), .irq(irq), .cnt(cnt), .haddr(haddr),
  .done(done), .wrap(wrap), .en(en)
);

// File: tb/sim_xfer_tracker.sv
`timescale 1ns/1ps
module sim_xfer_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        xfer_ok = 1'b0;
  logic        haddr_load = 1'b0;
  logic [31:0] haddr_in = '0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_addr = '0;

  always #2 clk = ~clk;

  xfer_tracker u0 (.*);

  // entry: [17:14] requirement, [13:12] op (0 write, 1 read-check, 2 strobe), [11:8] offset, [7:0] data
  localparam int NV = 20;
  localparam logic [17:0] VEC [NV] = '{
    {4'd2, 2'd0, 4'h0, 8'h03}, {4'd2, 2'd0, 4'h1, 8'h00}, {4'd2, 2'd0, 4'h2, 8'h00},
    {4'd2, 2'd1, 4'h0, 8'h03}, {4'd2, 2'd1, 4'h1, 8'h00},
    {4'd3, 2'd2, 4'h0, 8'h00}, {4'd3, 2'd1, 4'h0, 8'h02}, {4'd3, 2'd1, 4'h8, 8'h01},
    {4'd3, 2'd2, 4'h0, 8'h00}, {4'd3, 2'd2, 4'h0, 8'h00},
    {4'd5, 2'd1, 4'h0, 8'h00}, {4'd5, 2'd1, 4'h5, 8'h01},
    {4'd5, 2'd0, 4'h2, 8'h10}, {4'd5, 2'd1, 4'h5, 8'h01}, {4'd2, 2'd1, 4'h2, 8'h10},
    {4'd7, 2'd0, 4'h5, 8'h00}, {4'd7, 2'd1, 4'h5, 8'h01},
    {4'd7, 2'd0, 4'h5, 8'h01}, {4'd7, 2'd1, 4'h5, 8'h00},
    {4'd3, 2'd1, 4'h8, 8'h03}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [3:0] a, input logic [7:0] d,
                       input logic s, input logic hl, input logic [31:0] hv);
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; xfer_ok = s; haddr_load = hl; haddr_in = hv;
    @(posedge clk);
    #1;
    reg_wr = 1'b0; xfer_ok = 1'b0; haddr_load = 1'b0;
    if (hl) exp_addr = hv;
    else if (s) exp_addr = exp_addr + 32'd1;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    @(negedge clk);
    check(tag, {7'b0, irq}, {7'b0, exp});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 12; a++) rd("R1 reset readback", 4'(a), 8'h00);
    chk_irq("R1 reset irq", 1'b0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][13:12])
        2'd0: drive(1'b1, VEC[i][11:8], VEC[i][7:0], 1'b0, 1'b0, '0);
        2'd1: rd($sformatf("R%0d table[%0d]", VEC[i][17:14], i), VEC[i][11:8], VEC[i][7:0]);
        default: drive(1'b0, 4'h0, 8'h00, 1'b1, 1'b0, '0);
      endcase
    end

    // R4 count write with strobe in the same cycle
    drive(1'b1, 4'h0, 8'h05, 1'b0, 1'b0, '0);
    drive(1'b1, 4'h0, 8'h20, 1'b1, 1'b0, '0);
    rd("R4 written byte wins", 4'h0, 8'h20);
    rd("R4 other byte kept", 4'h2, 8'h10);
    rd("R4 address still steps", 4'h8, exp_addr[7:0]);

    // R8 control clear
    drive(1'b1, 4'h4, 8'h00, 1'b0, 1'b0, '0);
    rd("R8 zero bit no effect", 4'h0, 8'h20);
    rd("R8 control reads zero", 4'h4, 8'h00);
    drive(1'b1, 4'h4, 8'h01, 1'b0, 1'b0, '0);
    rd("R8 cleared byte0", 4'h0, 8'h00);
    rd("R8 cleared byte2", 4'h2, 8'h00);
    rd("R8 clear sets no done", 4'h5, 8'h00);

    // R6 wrap
    drive(1'b0, 4'h0, 8'h00, 1'b1, 1'b0, '0);
    rd("R6 wrap byte0", 4'h0, 8'hFF);
    rd("R6 wrap byte1", 4'h1, 8'hFF);
    rd("R6 wrap byte2", 4'h2, 8'hFF);
    rd("R6 wrap flag only", 4'h5, 8'h02);

    // R10 interrupt enables
    chk_irq("R10 masked", 1'b0);
    drive(1'b1, 4'h6, 8'h01, 1'b0, 1'b0, '0);
    chk_irq("R10 done enable, done clear", 1'b0);
    drive(1'b1, 4'h6, 8'h02, 1'b0, 1'b0, '0);
    chk_irq("R10 wrap enabled", 1'b1);
    rd("R10 enable readback", 4'h6, 8'h02);

    // R7 set wins over clear in the same cycle
    drive(1'b1, 4'h4, 8'h01, 1'b0, 1'b0, '0);
    drive(1'b1, 4'h5, 8'h02, 1'b1, 1'b0, '0);
    rd("R7 set beats clear", 4'h5, 8'h02);
    drive(1'b1, 4'h5, 8'h02, 1'b0, 1'b0, '0);
    rd("R7 wrap cleared", 4'h5, 8'h00);
    chk_irq("R7 irq drops", 1'b0);

    // R9 address read-only, load priority
    drive(1'b1, 4'h8, 8'h55, 1'b0, 1'b0, '0);
    rd("R9 write ignored", 4'h8, exp_addr[7:0]);
    drive(1'b0, 4'h0, 8'h00, 1'b1, 1'b1, 32'h12345678);
    rd("R9 load byte0", 4'h8, 8'h78);
    rd("R9 load byte1", 4'h9, 8'h56);
    rd("R9 load byte2", 4'hA, 8'h34);
    rd("R9 load byte3", 4'hB, 8'h12);
    drive(1'b0, 4'h0, 8'h00, 1'b1, 1'b0, '0);
    rd("R3 step after load", 4'h8, 8'h79);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule